// File: doc/BRIEF.md
# Compact Serial Port with Word-Addressed Control Registers

This block is a small asynchronous serial port for a control processor that only needs a console or debug link. Software reaches it through a synchronous register port with one word per address. It writes bytes into an 8-entry transmit queue and reads received bytes from an 8-entry receive queue. The transmitter and receiver move frames made of one low start bit, seven or eight data bits sent least significant bit first, and one high stop bit. There is no parity bit and no error checking beyond an overrun flag.

The bit timing comes from a 16-bit divider. A tick occurs every (divider + 1) clocks, and eight ticks make one bit. The receiver confirms a start bit halfway through it before it accepts a frame. One request-to-send output is driven by software, and one clear-to-send input can be read back. A single interrupt line combines a receive condition and a transmit condition, each with its own enable. The register layout follows the familiar 16550 arrangement for the first eight words and adds three extra words.

Top module: `mini_serial_port`

## Requirements
- R1: After reset, txd is 1, irq and rts are 0, the line status word (address 5) reads 0x0060, the interrupt identity word (address 2) reads 0x0001, the format word (address 3) and the divider (address 10) read 0, and the enable word (address 8) reads 0x0003.
- R2: Writes to bits a register does not implement have no effect, and those bits read as 0. The enable word (8) has bit 1 for the transmitter and bit 0 for the receiver. The scratch word (7) keeps 8 bits, the interrupt enable (1) keeps 2 bits, and the divider (10) keeps all 16 bits.
- R3: A write to address 0 queues a byte. Each queued byte leaves txd as start 0, data least significant bit first, then stop 1, and txd rests at 1 between frames.
- R4: Bit 0 of the format word selects the width: value 3 gives 8 data bits and value 0 gives 7. In 7-bit mode, bit 7 of a queued byte is not sent, and a received byte reads with bit 7 equal to 0.
- R5: Every bit lasts exactly 8 × (divider + 1) clock cycles on txd.
- R6: The transmit queue holds 8 bytes. Line status bit 5 reads 0 while the queue is full, and a write made while it is full is dropped.
- R7: Received bytes are read from address 0 in arrival order, each read removes one byte, line status bit 0 shows that a byte is waiting, and a read of an empty queue returns 0.
- R8: A byte that completes while the receive queue holds 8 is discarded and sets line status bit 1. A read of the line status word clears that bit.
- R9: A low level on rxd that has ended before the middle of the start bit is rejected, and no byte is received.
- R10: With enable bit 1 clear, queued bytes wait and txd stays at 1. With enable bit 0 clear, incoming frames are ignored.
- R11: Writing address 2 with bit 1 set empties the receive queue, and with bit 2 set it empties the transmit queue.
- R12: irq equals (enable bit 0 and receive queue not empty) or (enable bit 1 and transmit queue empty). Address 2 reads bit 2 for the receive condition and bit 1 for the transmit condition, only when the receive condition is absent, and bit 0 equals the inverse of irq.
- R13: Bit 1 of address 4 drives rts, and bit 5 of address 6 reads the cts input after two synchronising flops.

Line status (address 5) also carries bit 6, which reads 1 when the transmit queue is empty and the shifter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; side effects happen at the clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rts | output | 1 | Request-to-send, software driven |
| cts | input | 1 | Clear-to-send input |
| irq | output | 1 | Interrupt request |

## Verification
The assertions expect reg_rd and reg_wr to be single-cycle strobes that change only between clock edges. They also expect rxd to hold each level for a whole bit period at the programmed rate, apart from the deliberate short glitch used for R9. The bench drives every input on the falling clock edge, holds each serial bit for exactly 8 × (divider + 1) cycles, and changes the divider or the format only while both lines are idle. A scoreboard compares the bytes decoded from txd with the bytes the bench queued. This is how it detects missing, extra or corrupted frames.

// File: rtl/mini_serial_port.sv
module mini_serial_port #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16,
  parameter int OVS   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [DIV_W-1:0] reg_wdata,
  output logic [DIV_W-1:0] reg_rdata,
  output logic             txd,
  input  logic             rxd,
  output logic             rts,
  input  logic             cts,
  output logic             irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int TW = $clog2(OVS);
  localparam logic [TW-1:0] SUB_LAST = TW'(OVS - 1);
  localparam logic [TW-1:0] SUB_HALF = TW'(OVS / 2);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  localparam logic [3:0] A_DATA = 4'd0, A_IEN = 4'd1, A_IID = 4'd2, A_FMT = 4'd3,
                         A_MOD = 4'd4, A_LST = 4'd5, A_MST = 4'd6, A_SCR = 4'd7,
                         A_ENA = 4'd8, A_XST = 4'd9, A_DIV = 4'd10;

  logic [1:0]       ier, lcr, ctrl;
  logic             rts_q, ovr;
  logic [7:0]       scratch;
  logic [DIV_W-1:0] divr;

  logic wr_data, wr_iid, rd_data, rd_lst;
  assign wr_data = reg_wr && reg_addr == A_DATA;
  assign wr_iid  = reg_wr && reg_addr == A_IID;
  assign rd_data = reg_rd && reg_addr == A_DATA;
  assign rd_lst  = reg_rd && reg_addr == A_LST;

  // synchronisers
  logic rx_s1, rx_s2, cts_s1, cts_s2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rx_s1, rx_s2, cts_s1, cts_s2} <= 4'b1100;
    else begin
      rx_s1 <= rxd; rx_s2 <= rx_s1;
      cts_s1 <= cts; cts_s2 <= cts_s1;
    end

  // control registers
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ier <= '0; lcr <= '0; ctrl <= 2'b11; rts_q <= 1'b0; scratch <= '0; divr <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_IEN: ier     <= reg_wdata[1:0];
        A_FMT: lcr     <= reg_wdata[1:0];
        A_MOD: rts_q   <= reg_wdata[1];
        A_SCR: scratch <= reg_wdata[7:0];
        A_ENA: ctrl    <= reg_wdata[1:0];
        A_DIV: divr    <= reg_wdata;
        default: ;
      endcase
    end

  // transmit queue
  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt;
  logic          tx_push, tx_load, tx_clr, tx_busy;
  assign tx_clr  = wr_iid && reg_wdata[2];
  assign tx_push = wr_data && tx_cnt != FULL;
  assign tx_load = !tx_busy && ctrl[1] && tx_cnt != '0;

  always_ff @(posedge clk)
    if (tx_push) tx_mem[tx_wp] <= reg_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_load) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_load);
    end

  // transmit shifter
  logic [9:0]       tx_frm;
  logic [3:0]       tx_left;
  logic [DIV_W-1:0] tx_div;
  logic [TW-1:0]    tx_sub;
  logic [7:0]       tx_byte;
  assign tx_byte = tx_mem[tx_rp];
  assign txd = tx_frm[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_frm <= '1; tx_left <= '0; tx_div <= '0; tx_sub <= '0; tx_busy <= 1'b0;
    end else if (tx_load) begin
      tx_frm  <= lcr[0] ? {1'b1, tx_byte, 1'b0} : {2'b11, tx_byte[6:0], 1'b0};
      tx_left <= lcr[0] ? 4'd10 : 4'd9;
      tx_div  <= '0;
      tx_sub  <= '0;
      tx_busy <= 1'b1;
    end else if (tx_busy) begin
      if (tx_div >= divr) begin
        tx_div <= '0;
        if (tx_sub == SUB_LAST) begin
          tx_sub  <= '0;
          tx_frm  <= {1'b1, tx_frm[9:1]};
          tx_left <= tx_left - 1'b1;
          if (tx_left == 4'd1) tx_busy <= 1'b0;
        end else tx_sub <= tx_sub + 1'b1;
      end else tx_div <= tx_div + 1'b1;
    end

  // receiver
  logic             rx_busy, rx_n8, rx_done;
  logic [3:0]       rx_idx;
  logic [DIV_W-1:0] rx_div;
  logic [TW-1:0]    rx_sub;
  logic [7:0]       rx_sh, rx_byte;
  logic             rx_smp;
  assign rx_smp = rx_busy && rx_div >= divr && rx_sub == SUB_LAST;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0; rx_n8 <= 1'b0; rx_done <= 1'b0; rx_idx <= '0;
      rx_div <= '0; rx_sub <= '0; rx_sh <= '0; rx_byte <= '0;
    end else begin
      rx_done <= 1'b0;
      if (!rx_busy) begin
        if (ctrl[0] && !rx_s2) begin
          rx_busy <= 1'b1; rx_n8 <= lcr[0]; rx_idx <= '0;
          rx_div <= '0; rx_sub <= SUB_HALF;
        end
      end else if (rx_div >= divr) begin
        rx_div <= '0;
        rx_sub <= rx_sub + 1'b1;
        if (rx_smp) begin
          rx_sub <= '0;
          if (rx_idx == '0) begin
            if (rx_s2) rx_busy <= 1'b0;
            else rx_idx <= 4'd1;
          end else if (rx_idx == (rx_n8 ? 4'd9 : 4'd8)) begin
            rx_busy <= 1'b0;
            rx_done <= 1'b1;
            rx_byte <= rx_n8 ? rx_sh : {1'b0, rx_sh[7:1]};
          end else begin
            rx_sh  <= {rx_s2, rx_sh[7:1]};
            rx_idx <= rx_idx + 1'b1;
          end
        end
      end else rx_div <= rx_div + 1'b1;
    end

  // receive queue
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt;
  logic          rx_push, rx_pop, rx_clr;
  assign rx_clr  = wr_iid && reg_wdata[1];
  assign rx_push = rx_done && rx_cnt != FULL && !rx_clr;
  assign rx_pop  = rd_data && rx_cnt != '0;

  always_ff @(posedge clk)
    if (rx_push) rx_mem[rx_wp] <= rx_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0; ovr <= 1'b0;
    end else begin
      if (rx_done && rx_cnt == FULL) ovr <= 1'b1;
      else if (rd_lst) ovr <= 1'b0;
      if (rx_clr) begin
        rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      end else begin
        if (rx_push) rx_wp <= rx_wp + 1'b1;
        if (rx_pop)  rx_rp <= rx_rp + 1'b1;
        rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      end
    end

  // status, interrupt, read mux
  logic rx_avail, tx_space, tx_idle, rx_irq, tx_irq;
  assign rx_avail = rx_cnt != '0;
  assign tx_space = tx_cnt != FULL;
  assign tx_idle  = tx_cnt == '0 && !tx_busy;
  assign rx_irq   = ier[0] && rx_avail;
  assign tx_irq   = ier[1] && tx_cnt == '0;
  assign irq      = rx_irq || tx_irq;
  assign rts      = rts_q;

  always_comb
    case (reg_addr)
      A_DATA:  reg_rdata = rx_avail ? DIV_W'(rx_mem[rx_rp]) : '0;
      A_IEN:   reg_rdata = DIV_W'(ier);
      A_IID:   reg_rdata = DIV_W'({rx_irq, tx_irq && !rx_irq, !irq});
      A_FMT:   reg_rdata = DIV_W'(lcr);
      A_MOD:   reg_rdata = DIV_W'({rts_q, 1'b0});
      A_LST:   reg_rdata = DIV_W'({tx_idle, tx_space, 3'b000, ovr, rx_avail});
      A_MST:   reg_rdata = DIV_W'({cts_s2, 5'b00000});
      A_SCR:   reg_rdata = DIV_W'(scratch);
      A_ENA:   reg_rdata = DIV_W'(ctrl);
      A_XST:   reg_rdata = DIV_W'({tx_space, rx_avail});
      A_DIV:   reg_rdata = divr;
      default: reg_rdata = '0;
    endcase
endmodule

// File: rtl/mini_serial_port_chk.sv
module mini_serial_port_chk #(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [3:0]                 reg_addr,
  input logic [DIV_W-1:0]           reg_rdata,
  input logic                       txd,
  input logic                       irq,
  input logic [1:0]                 ier,
  input logic [1:0]                 ctrl,
  input logic                       tx_busy,
  input logic                       ovr,
  input logic [$clog2(DEPTH):0]     tx_cnt,
  input logic [$clog2(DEPTH):0]     rx_cnt
);
  a_r6_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= ($clog2(DEPTH)+1)'(DEPTH) && rx_cnt <= ($clog2(DEPTH)+1)'(DEPTH));

  a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  a_r8_overrun_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(rx_cnt) == ($clog2(DEPTH)+1)'(DEPTH));

  a_r10_tx_held: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[1] |=> !$rose(tx_busy));

  a_r12_iid_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 4'd2 |-> !(reg_rdata[2] && reg_rdata[1]));

  a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ier != 2'b00);
endmodule

bind mini_serial_port mini_serial_port_chk #(.DEPTH(DEPTH), .DIV_W(DIV_W)) chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .txd(txd), .irq(irq), .ier(ier), .ctrl(ctrl), .tx_busy(tx_busy),
  .ovr(ovr), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt));

// File: tb/mini_serial_port_test.sv
`timescale 1ns/100ps
module mini_serial_port_test;
  logic clk = 0, rst_n = 0;
  logic [3:0] reg_addr = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;
  logic txd, rts, irq;
  logic rxd = 1, cts = 0;

  mini_serial_port uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int bit_clks = 16;
  int nbits = 8;
  logic [7:0] txq[$];
  logic [7:0] rxq[$];

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic tx_send(logic [7:0] b, bit expect_it);
    if (expect_it) txq.push_back(nbits == 8 ? b : (b & 8'h7f));
    wr(4'd0, {8'h00, b});
  endtask

  task automatic rx_send(logic [7:0] b);
    rxq.push_back(nbits == 8 ? b : (b & 8'h7f));
    @(negedge clk); rxd = 0;
    repeat (bit_clks) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rxd = b[i];
      repeat (bit_clks) @(negedge clk);
    end
    rxd = 1;
    repeat (bit_clks) @(negedge clk);
  endtask

  task automatic rx_take(string req);
    logic [15:0] v;
    rd(4'd0, v);
    chk(req, v, {8'h00, rxq.pop_front()});
  endtask

  task automatic drain();
    logic [15:0] v;
    v = 0;
    while (!v[6]) rd(4'd5, v);
    repeat (2 * bit_clks) @(negedge clk);
    chk("R3 queue drained", 16'(txq.size()), 16'd0);
  endtask

  // monitor: decode txd and compare against the scoreboard queue
  initial begin
    logic [7:0] b;
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0) begin
        repeat (bit_clks / 2) @(negedge clk);
        chk("R3 start bit", 16'(txd), 16'd0);
        b = 0;
        for (int i = 0; i < nbits; i++) begin
          repeat (bit_clks) @(negedge clk);
          b[i] = txd;
        end
        repeat (bit_clks) @(negedge clk);
        chk("R3 stop bit", 16'(txd), 16'd1);
        if (txq.size() == 0) chk("R6 unexpected frame", 16'(b), 16'hxxxx);
        else chk("R3 frame data", 16'(b), 16'(txq.pop_front()));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txd", 16'(txd), 16'd1);
    chk("R1 irq", 16'(irq), 16'd0);
    chk("R1 rts", 16'(rts), 16'd0);
    rd_chk("R1 line status", 4'd5, 16'h0060);
    rd_chk("R1 identity", 4'd2, 16'h0001);
    rd_chk("R1 format", 4'd3, 16'h0000);
    rd_chk("R1 enables", 4'd8, 16'h0003);
    rd_chk("R1 divider", 4'd10, 16'h0000);

    // R2 / R13 register widths and pins
    wr(4'd4, 16'hffff);
    rd_chk("R2 modem ctrl bits", 4'd4, 16'h0002);
    chk("R13 rts high", 16'(rts), 16'd1);
    wr(4'd3, 16'hffff);
    rd_chk("R2 format bits", 4'd3, 16'h0003);
    wr(4'd1, 16'hffff);
    rd_chk("R2 enable bits", 4'd1, 16'h0003);
    wr(4'd1, 16'h0000);
    wr(4'd7, 16'h1234);
    rd_chk("R2 scratch", 4'd7, 16'h0034);
    wr(4'd10, 16'hbeef);
    rd_chk("R2 divider", 4'd10, 16'hbeef);
    @(negedge clk); cts = 1; repeat (3) @(negedge clk);
    rd_chk("R13 cts high", 4'd6, 16'h0020);
    @(negedge clk); cts = 0; repeat (3) @(negedge clk);
    rd_chk("R13 cts low", 4'd6, 16'h0000);
    wr(4'd4, 16'h0000);
    chk("R13 rts low", 16'(rts), 16'd0);
    wr(4'd10, 16'd1);

    // R3 8-bit transmit
    tx_send(8'ha5, 1); tx_send(8'h3c, 1); tx_send(8'h81, 1);
    drain();

    // R4 7-bit mode
    wr(4'd3, 16'd0); nbits = 7;
    tx_send(8'hc1, 1); tx_send(8'h7f, 1);
    drain();
    rx_send(8'hff);
    rx_take("R4 7-bit receive");
    wr(4'd3, 16'd3); nbits = 8;

    // R5 bit period with divider 3
    wr(4'd10, 16'd3); bit_clks = 32;
    tx_send(8'h00, 1);
    @(negedge clk);
    while (txd) @(negedge clk);
    n = 0;
    while (!txd) begin n++; @(negedge clk); end
    chk("R5 nine low bits", 16'(n), 16'd288);
    drain();
    wr(4'd10, 16'd1); bit_clks = 16;

    // R6 / R10 queue depth with transmitter held
    wr(4'd8, 16'd1);
    for (int i = 0; i < 9; i++) tx_send(8'h10 + 8'(i), i < 8);
    rd_chk("R6 full status", 4'd5, 16'h0000);
    repeat (40) @(negedge clk);
    chk("R10 txd held", 16'(txd), 16'd1);
    wr(4'd8, 16'd3);
    drain();

    // R11 queue clears
    wr(4'd8, 16'd1);
    tx_send(8'h01, 0); tx_send(8'h02, 0); tx_send(8'h03, 0);
    wr(4'd2, 16'h0004);
    rd_chk("R11 tx cleared", 4'd5, 16'h0060);
    wr(4'd8, 16'd3);
    repeat (3 * bit_clks) @(negedge clk);
    rx_send(8'h11); rx_send(8'h22);
    rd_chk("R11 rx holds data", 4'd5, 16'h0061);
    wr(4'd2, 16'h0002);
    rxq.delete();
    rd_chk("R11 rx cleared", 4'd5, 16'h0060);

    // R7 receive order
    rx_send(8'h5a); rx_send(8'hc3); rx_send(8'h00);
    rd_chk("R7 data waiting", 4'd5, 16'h0061);
    rx_take("R7 byte 1"); rx_take("R7 byte 2"); rx_take("R7 byte 3");
    rd_chk("R7 queue empty", 4'd5, 16'h0060);
    rd_chk("R7 empty read", 4'd0, 16'h0000);

    // R12 interrupt and identity
    wr(4'd1, 16'd1);
    chk("R12 no irq when empty", 16'(irq), 16'd0);
    rd_chk("R12 identity idle", 4'd2, 16'h0001);
    rx_send(8'h77);
    chk("R12 rx irq", 16'(irq), 16'd1);
    rd_chk("R12 rx identity", 4'd2, 16'h0004);
    wr(4'd1, 16'd3);
    rd_chk("R12 rx priority", 4'd2, 16'h0004);
    rx_take("R12 rx byte");
    rd_chk("R12 tx identity", 4'd2, 16'h0002);
    chk("R12 tx irq", 16'(irq), 16'd1);
    wr(4'd1, 16'd2); wr(4'd8, 16'd1);
    tx_send(8'h44, 0);
    chk("R12 tx irq off", 16'(irq), 16'd0);
    wr(4'd2, 16'h0004);
    chk("R12 tx irq after clear", 16'(irq), 16'd1);
    wr(4'd1, 16'd0);
    chk("R12 irq masked", 16'(irq), 16'd0);
    wr(4'd8, 16'd3);

    // R8 overrun
    for (int i = 0; i < 9; i++) rx_send(8'h80 + 8'(i));
    void'(rxq.pop_back());
    rd_chk("R8 overrun set", 4'd5, 16'h0063);
    rd_chk("R8 overrun cleared", 4'd5, 16'h0061);
    for (int i = 0; i < 8; i++) rx_take("R8 kept byte");
    rd_chk("R8 empty after", 4'd5, 16'h0060);

    // R9 short start rejected
    @(negedge clk); rxd = 0;
    repeat (2) @(negedge clk); rxd = 1;
    repeat (3 * bit_clks) @(negedge clk);
    rd_chk("R9 glitch ignored", 4'd5, 16'h0060);
    rx_send(8'h96);
    rx_take("R9 recovery byte");

    // R10 receiver disabled
    wr(4'd8, 16'd2);
    rx_send(8'h55);
    rxq.delete();
    rd_chk("R10 rx ignored", 4'd5, 16'h0060);
    wr(4'd8, 16'd3);

    drain();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule